// File: doc/BRIEF.md
# Chainable DMA Channel Controller

This block sequences a small bank of DMA channels, four by default. Each channel holds a source address, a destination address, an element count and a control word. A busy channel moves one element per granted cycle: it reads through a memory-style read port and writes the same data through a memory-style write port in that cycle. After each element it steps its addresses by the element size and decrements its count. When several channels are ready in one cycle, the lowest-numbered channel moves.

Software programs the channels through a simple word-addressed register bus. Three things start a channel. One is a write to a trigger alias of the destination address. Another is a bitmask write that starts several channels in the same cycle. The last is a hand-off from another channel that has finished. A channel that finishes sets its bit in a shared completion status register. Each of two interrupt lines has its own per-channel enable mask.

Each element is paced by a request line chosen per channel, or it runs unpaced. This lets a channel follow a peripheral's data rate or copy memory at full speed.

Top module: `dma_chain_ctrl`

## Requirements
- R1: After reset every channel register, the status register and both enable masks read zero. Both interrupt lines are low and neither memory port is enabled.
- R2: The control word is read at bus word ch*8+3. Its fields are: bit 0 enable, bits 2:1 element size (0 byte, 1 halfword, 2 word, 3 treated as word), bit 3 source increment, bit 4 destination increment, bits 10:5 pacing select, bits 14:11 hand-off channel, and bit 31 busy (read-only). After each element, an address whose increment flag is set advances by 1, 2 or 4 according to the size. An address whose flag is clear stays where it is.
- R3: A busy channel that is granted copies one element from the source to the destination and decrements its count (word ch*8+2) by one. When the count reaches zero in that cycle, busy clears and bit ch of the status register (word 0x43) sets.
- R4: A write to word ch*8+4 loads the destination address and starts the channel. A write to word ch*8+1 loads the same destination address without starting anything.
- R5: A write to word 0x40 starts, at the same clock edge, every channel whose bit is set in the written value.
- R6: A start request is ignored if the channel's enable bit is clear, if the channel is already busy, or if its count is zero. While a channel is busy, bus writes to its address and count registers are ignored.
- R7: With pacing select 0x3F the channel moves on every cycle it is granted. A select value below the number of request lines makes each element wait until that request line is high. Any other value stalls the channel.
- R8: When a channel finishes, the channel named in its hand-off field is started one cycle later, under the rules of R6. A hand-off naming the finishing channel itself, or a channel that does not exist, starts nothing.
- R9: Words 0x41 and 0x42 hold the enable masks of interrupt lines irq0 and irq1. A line is high while any channel has its status bit and its enable bit for that line both set. Writing 1 to a bit of word 0x43 clears that status bit.
- R10: If a channel finishes in the same cycle as a write of 1 to its status bit, the bit ends set.
- R11: At most one channel moves per cycle. Among ready channels, the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| dreq | input | NREQ | Pacing request lines |
| mem_rd_en | output | 1 | Read port enable |
| mem_rd_addr | output | ADDR_W | Read byte address |
| mem_rd_data | input | 32 | Read data, combinational from mem_rd_addr |
| mem_wr_en | output | 1 | Write port enable |
| mem_wr_addr | output | ADDR_W | Write byte address |
| mem_wr_data | output | 32 | Write data, low lanes significant |
| mem_size | output | 2 | Element size of the current move |
| irq0 | output | 1 | Interrupt line 0 |
| irq1 | output | 1 | Interrupt line 1 |

## Verification
Two events can land on the same clock edge: a channel's final element setting its status bit, and a software write of 1 clearing that bit. The bench starts a one-element unpaced channel through the trigger alias and puts the clear write on the very next bus cycle, which is the edge where the move completes. It then expects the bit to read set. A later clear write with no completion must bring the bit back to zero, which shows that the clear works on its own.

// File: rtl/dma_cc_pkg.sv
package dma_cc_pkg;

   // register slots inside one channel's eight-word window
   localparam logic [2:0] SLOT_SRC   = 3'd0;
   localparam logic [2:0] SLOT_DST   = 3'd1;
   localparam logic [2:0] SLOT_CNT   = 3'd2;
   localparam logic [2:0] SLOT_CTRL  = 3'd3;
   localparam logic [2:0] SLOT_DSTGO = 3'd4;

   // shared registers above the channel windows
   localparam logic [6:0] G_MULTI = 7'h40;
   localparam logic [6:0] G_IEN0  = 7'h41;
   localparam logic [6:0] G_IEN1  = 7'h42;
   localparam logic [6:0] G_STAT  = 7'h43;

   localparam logic [5:0] REQ_FREE = 6'h3F;
   localparam int         CTRL_W   = 15;

   typedef struct packed {
      logic [3:0] chain;
      logic [5:0] req_sel;
      logic       inc_dst;
      logic       inc_src;
      logic [1:0] size;
      logic       en;
   } ctrl_t;

   function automatic logic [2:0] step_of(input logic [1:0] sz);
      case (sz)
         2'd0:    return 3'd1;
         2'd1:    return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

   function automatic logic [1:0] size_norm(input logic [1:0] sz);
      return (sz == 2'd3) ? 2'd2 : sz;
   endfunction

endpackage

// File: rtl/dma_cc_pace.sv
module dma_cc_pace
   import dma_cc_pkg::*;
#(
   parameter int NREQ = 4
)(
   input  logic [5:0]      sel,
   input  logic [NREQ-1:0] dreq,
   output logic            ready
);

   logic [NREQ-1:0] hit;

   generate
      for (genvar k = 0; k < NREQ; k++) begin : g_line
         assign hit[k] = (sel == 6'(k)) && dreq[k];
      end
   endgenerate

   assign ready = (sel == REQ_FREE) || (|hit);

endmodule

// File: rtl/dma_cc_chan.sv
module dma_cc_chan
   import dma_cc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 32,
   parameter int NREQ   = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_src,
   input  logic              wr_dst,
   input  logic              wr_cnt,
   input  logic              wr_ctrl,
   input  logic [31:0]       wdata,
   input  logic              trig,
   input  logic              grant,
   input  logic [NREQ-1:0]   dreq,
   output logic [ADDR_W-1:0] src,
   output logic [ADDR_W-1:0] dst,
   output logic [CNT_W-1:0]  cnt,
   output ctrl_t             ctrl,
   output logic              busy,
   output logic              req,
   output logic              done
);

   logic              ready;
   logic              start;
   logic              last;
   logic [ADDR_W-1:0] step;

   dma_cc_pace #(.NREQ(NREQ)) u_pace (
      .sel   (ctrl.req_sel),
      .dreq  (dreq),
      .ready (ready)
   );

   assign step  = ADDR_W'(step_of(ctrl.size));
   assign last  = (cnt == CNT_W'(1));
   assign start = trig && ctrl.en && !busy && (cnt != '0);
   assign req   = busy && ready;
   assign done  = grant && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
      end else if (start) begin
         busy <= 1'b1;
      end else if (done) begin
         busy <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src <= '0;
         dst <= '0;
         cnt <= '0;
      end else begin
         if (wr_src && !busy) begin
            src <= wdata[ADDR_W-1:0];
         end else if (grant && ctrl.inc_src) begin
            src <= src + step;
         end
         if (wr_dst && !busy) begin
            dst <= wdata[ADDR_W-1:0];
         end else if (grant && ctrl.inc_dst) begin
            dst <= dst + step;
         end
         if (wr_cnt && !busy) begin
            cnt <= wdata[CNT_W-1:0];
         end else if (grant) begin
            cnt <= cnt - CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (wr_ctrl) begin
         ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
      end
   end

endmodule

// File: rtl/dma_cc_sched.sv
module dma_cc_sched #(
   parameter int NCH = 4
)(
   input  logic [NCH-1:0] req,
   output logic [NCH-1:0] grant
);

   always_comb begin
      logic taken;
      taken = 1'b0;
      grant = '0;
      for (int i = 0; i < NCH; i++) begin
         if (req[i] && !taken) begin
            grant[i] = 1'b1;
            taken    = 1'b1;
         end
      end
   end

endmodule

// File: rtl/dma_cc_irq.sv
module dma_cc_irq #(
   parameter int NCH = 4
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_ien0,
   input  logic           wr_ien1,
   input  logic           wr_stat,
   input  logic [NCH-1:0] wdata,
   input  logic [NCH-1:0] done,
   output logic [NCH-1:0] status,
   output logic [NCH-1:0] ien0,
   output logic [NCH-1:0] ien1,
   output logic           irq0,
   output logic           irq1
);

   logic [NCH-1:0] clr;

   assign clr = wr_stat ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         ien0   <= '0;
         ien1   <= '0;
      end else begin
         // a completion in the same cycle beats a software clear
         status <= (status & ~clr) | done;
         if (wr_ien0) ien0 <= wdata;
         if (wr_ien1) ien1 <= wdata;
      end
   end

   assign irq0 = |(status & ien0);
   assign irq1 = |(status & ien1);

endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl
   import dma_cc_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int NREQ   = 4,
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_en,
   input  logic [6:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NREQ-1:0]   dreq,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [31:0]       mem_rd_data,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [31:0]       mem_wr_data,
   output logic [1:0]        mem_size,
   output logic              irq0,
   output logic              irq1
);

   localparam int CHAN_AW = 3;

   generate
      if (NCH < 1 || NCH > (1 << CHAN_AW)) begin : g_bad_nch
         $error("NCH must lie in 1..8");
      end
      if (NREQ < 1 || NREQ > 62) begin : g_bad_nreq
         $error("NREQ must lie in 1..62");
      end
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_aw
         $error("ADDR_W must lie in 8..32");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cw
         $error("CNT_W must lie in 1..32");
      end
   endgenerate

   logic [NCH-1:0]    busy_v, done_v, req_v, grant_v, cnt_nz_v;
   logic [NCH-1:0]    trig_v, chain_d, chain_q;
   logic [NCH-1:0]    stat_v, ien0_v, ien1_v;
   logic [ADDR_W-1:0] src_v [NCH];
   logic [ADDR_W-1:0] dst_v [NCH];
   logic [CNT_W-1:0]  cnt_v [NCH];
   ctrl_t             ctrl_v [NCH];

   logic       glob_sel;
   logic       multi_wr;
   logic [2:0] slot;

   assign glob_sel = bus_addr[6];
   assign slot     = bus_addr[2:0];
   assign multi_wr = bus_wr_en && (bus_addr == G_MULTI);

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         logic hit;
         assign hit = bus_wr_en && !glob_sel && (bus_addr[5:3] == CHAN_AW'(i));
         assign trig_v[i] = (hit && slot == SLOT_DSTGO) ||
                            (multi_wr && bus_wdata[i]) || chain_q[i];
         assign cnt_nz_v[i] = |cnt_v[i];

         dma_cc_chan #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W),
            .NREQ   (NREQ)
         ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_src  (hit && slot == SLOT_SRC),
            .wr_dst  (hit && (slot == SLOT_DST || slot == SLOT_DSTGO)),
            .wr_cnt  (hit && slot == SLOT_CNT),
            .wr_ctrl (hit && slot == SLOT_CTRL),
            .wdata   (bus_wdata),
            .trig    (trig_v[i]),
            .grant   (grant_v[i]),
            .dreq    (dreq),
            .src     (src_v[i]),
            .dst     (dst_v[i]),
            .cnt     (cnt_v[i]),
            .ctrl    (ctrl_v[i]),
            .busy    (busy_v[i]),
            .req     (req_v[i]),
            .done    (done_v[i])
         );
      end
   endgenerate

   dma_cc_sched #(.NCH(NCH)) u_sched (
      .req   (req_v),
      .grant (grant_v)
   );

   dma_cc_irq #(.NCH(NCH)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ien0 (bus_wr_en && bus_addr == G_IEN0),
      .wr_ien1 (bus_wr_en && bus_addr == G_IEN1),
      .wr_stat (bus_wr_en && bus_addr == G_STAT),
      .wdata   (bus_wdata[NCH-1:0]),
      .done    (done_v),
      .status  (stat_v),
      .ien0    (ien0_v),
      .ien1    (ien1_v),
      .irq0    (irq0),
      .irq1    (irq1)
   );

   // hand-off: a finishing channel pulses its named partner one cycle later
   always_comb begin
      chain_d = '0;
      for (int i = 0; i < NCH; i++) begin
         for (int j = 0; j < NCH; j++) begin
            if (i != j && done_v[i] && ctrl_v[i].chain == 4'(j)) begin
               chain_d[j] = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= chain_d;
      end
   end

   // datapath steering from the single granted channel
   always_comb begin
      mem_rd_addr = '0;
      mem_wr_addr = '0;
      mem_size    = '0;
      for (int i = 0; i < NCH; i++) begin
         if (grant_v[i]) begin
            mem_rd_addr = src_v[i];
            mem_wr_addr = dst_v[i];
            mem_size    = size_norm(ctrl_v[i].size);
         end
      end
   end

   assign mem_rd_en   = |grant_v;
   assign mem_wr_en   = |grant_v;
   assign mem_wr_data = mem_rd_data;

   // register read-back
   always_comb begin
      bus_rdata = '0;
      if (!glob_sel) begin
         for (int i = 0; i < NCH; i++) begin
            if (bus_addr[5:3] == CHAN_AW'(i)) begin
               case (slot)
                  SLOT_SRC:              bus_rdata = 32'(src_v[i]);
                  SLOT_DST, SLOT_DSTGO:  bus_rdata = 32'(dst_v[i]);
                  SLOT_CNT:              bus_rdata = 32'(cnt_v[i]);
                  SLOT_CTRL:             bus_rdata = {busy_v[i], 16'd0, ctrl_v[i]};
                  default:               bus_rdata = '0;
               endcase
            end
         end
      end else begin
         case (bus_addr)
            G_IEN0:  bus_rdata = 32'(ien0_v);
            G_IEN1:  bus_rdata = 32'(ien1_v);
            G_STAT:  bus_rdata = 32'(stat_v);
            default: bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/dma_cc_chk.sv
module dma_cc_chk #(
   parameter int NCH = 4
)(
   input logic           clk,
   input logic           rst_n,
   input logic [NCH-1:0] busy,
   input logic [NCH-1:0] done,
   input logic [NCH-1:0] grant,
   input logic [NCH-1:0] status,
   input logic [NCH-1:0] cnt_nz,
   input logic           irq0,
   input logic           irq1
);

   assert_one_mover_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (status == '0) |-> (!irq0 && !irq1));

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         assert_grant_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |-> busy[i]);

         assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
            done[i] |=> !busy[i]);

         assert_done_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
            done[i] |=> status[i]);

         assert_busy_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
            busy[i] |-> cnt_nz[i]);
      end
   endgenerate

endmodule

bind dma_chain_ctrl dma_cc_chk #(.NCH(NCH)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .busy   (busy_v),
   .done   (done_v),
   .grant  (grant_v),
   .status (stat_v),
   .cnt_nz (cnt_nz_v),
   .irq0   (irq0),
   .irq1   (irq1)
);

// File: tb/dma_chain_ctrl_tb_top.sv
module dma_chain_ctrl_tb_top;

   localparam int NCH  = 4;
   localparam int NREQ = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr_en = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NREQ-1:0] dreq = '0;
   logic        mem_rd_en, mem_wr_en;
   logic [31:0] mem_rd_addr, mem_wr_addr, mem_rd_data, mem_wr_data;
   logic [1:0]  mem_size;
   logic        irq0, irq1;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   dma_chain_ctrl #(.NCH(NCH), .NREQ(NREQ), .ADDR_W(32), .CNT_W(32)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .dreq(dreq),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .mem_size(mem_size), .irq0(irq0), .irq1(irq1)
   );

   // byte memory model, little endian, 256 bytes
   logic [7:0] mem [256];
   logic [7:0] ref_m [256];

   assign mem_rd_data = {mem[mem_rd_addr[7:0] + 8'd3], mem[mem_rd_addr[7:0] + 8'd2],
                         mem[mem_rd_addr[7:0] + 8'd1], mem[mem_rd_addr[7:0]]};

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
      end else if (mem_wr_en) begin
         mem[mem_wr_addr[7:0]] <= mem_wr_data[7:0];
         if (mem_size != 2'd0) mem[mem_wr_addr[7:0] + 8'd1] <= mem_wr_data[15:8];
         if (mem_size == 2'd2) begin
            mem[mem_wr_addr[7:0] + 8'd2] <= mem_wr_data[23:16];
            mem[mem_wr_addr[7:0] + 8'd3] <= mem_wr_data[31:24];
         end
      end
   end

   typedef struct packed {
      logic [7:0] src;
      logic [7:0] dst;
      logic [7:0] cnt;
      logic [1:0] sz;
      logic       ir;
      logic       iw;
   } vec_t;

   localparam vec_t VECS [4] = '{
      '{8'h00, 8'h80, 8'd4, 2'd2, 1'b1, 1'b1},
      '{8'h10, 8'h90, 8'd5, 2'd0, 1'b1, 1'b1},
      '{8'h20, 8'hA0, 8'd3, 2'd1, 1'b1, 1'b0},
      '{8'h30, 8'hB0, 8'd3, 2'd2, 1'b0, 1'b1}
   };

   function automatic logic [31:0] mk(input logic en, input logic [1:0] sz, input logic ir,
                                      input logic iw, input logic [5:0] rq, input logic [3:0] ch);
      return {17'd0, ch, rq, iw, ir, sz, en};
   endfunction

   function automatic int stepb(input logic [1:0] sz);
      return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // called just after a falling edge; the write lands on the next rising edge
   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      bus_wr_en = 1'b1;
      bus_addr  = a;
      bus_wdata = d;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [6:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_idle(input int ch);
      logic [31:0] d;
      for (int n = 0; n < 200; n++) begin
         rd(7'(ch * 8 + 3), d);
         if (!d[31]) break;
         @(negedge clk);
      end
   endtask

   task automatic ref_copy(input logic [7:0] s0, input logic [7:0] d0, input int cnt,
                           input logic [1:0] sz, input logic ir, input logic iw);
      logic [7:0] s, d;
      s = s0;
      d = d0;
      for (int e = 0; e < cnt; e++) begin
         for (int b = 0; b < stepb(sz); b++) ref_m[d + 8'(b)] = ref_m[s + 8'(b)];
         if (ir) s = s + 8'(stepb(sz));
         if (iw) d = d + 8'(stepb(sz));
      end
   endtask

   task automatic chk_mem(input string tag);
      int bad;
      int first;
      bad = 0;
      first = 0;
      for (int i = 0; i < 256; i++) begin
         if (mem[i] !== ref_m[i]) begin
            if (bad == 0) first = i;
            bad++;
         end
      end
      chk(bad == 0, tag, 32'(mem[first]), 32'(ref_m[first]));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d, d2;
      for (int i = 0; i < 256; i++) ref_m[i] = 8'(i * 7 + 3);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(!irq0 && !irq1, "R1 irq lines", {30'd0, irq1, irq0}, 32'd0);
      chk(!mem_rd_en && !mem_wr_en, "R1 mem idle", {30'd0, mem_wr_en, mem_rd_en}, 32'd0);
      rd(7'd3, d);  chk(d == 32'd0, "R1 ctrl ch0", d, 32'd0);
      rd(7'd10, d); chk(d == 32'd0, "R1 count ch1", d, 32'd0);
      rd(7'h43, d); chk(d == 32'd0, "R1 status", d, 32'd0);

      // table of transfers on channel 0 (self hand-off), unpaced
      for (int v = 0; v < 4; v++) begin
         wr(7'd0, 32'(VECS[v].src));
         wr(7'd2, 32'(VECS[v].cnt));
         wr(7'd3, mk(1'b1, VECS[v].sz, VECS[v].ir, VECS[v].iw, 6'h3F, 4'd0));
         wr(7'd4, 32'(VECS[v].dst));
         ref_copy(VECS[v].src, VECS[v].dst, int'(VECS[v].cnt), VECS[v].sz, VECS[v].ir, VECS[v].iw);
         wait_idle(0);
         @(negedge clk);
         chk_mem("R3 R2 copied data");
         rd(7'd0, d);
         d2 = 32'(VECS[v].src) + (VECS[v].ir ? 32'(int'(VECS[v].cnt) * stepb(VECS[v].sz)) : 32'd0);
         chk(d == d2, "R2 source address after run", d, d2);
         rd(7'h43, d);
         chk(d == 32'd1, "R3 R8 status only own bit", d, 32'd1);
         wr(7'h43, 32'd1);
      end

      // R4 plain destination write does not start
      wr(7'd8, 32'h40);
      wr(7'd10, 32'd2);
      wr(7'd11, mk(1'b1, 2'd2, 1'b1, 1'b1, 6'h3F, 4'd1));
      wr(7'd9, 32'hC0);
      repeat (4) @(negedge clk);
      rd(7'd11, d);  chk(!d[31], "R4 busy after plain write", d, 32'd0);
      rd(7'd10, d);  chk(d == 32'd2, "R4 count unchanged", d, 32'd2);
      chk_mem("R4 memory untouched");

      // R6 trigger with enable clear, and with zero count
      wr(7'd11, mk(1'b0, 2'd2, 1'b1, 1'b1, 6'h3F, 4'd1));
      wr(7'd12, 32'hC0);
      repeat (4) @(negedge clk);
      rd(7'd10, d);  chk(d == 32'd2, "R6 disabled channel count", d, 32'd2);
      wr(7'd18, 32'd0);
      wr(7'd19, mk(1'b1, 2'd2, 1'b1, 1'b1, 6'h3F, 4'd2));
      wr(7'd20, 32'hD0);
      repeat (4) @(negedge clk);
      rd(7'd19, d);  chk(!d[31], "R6 zero count busy", d, 32'd0);
      rd(7'h43, d);  chk(d == 32'd0, "R6 zero count status", d, 32'd0);

      // R5 multi trigger, R7 pacing hold, R11 priority
      wr(7'd11, mk(1'b1, 2'd2, 1'b1, 1'b1, 6'd0, 4'd1));
      wr(7'd16, 32'h60);
      wr(7'd18, 32'd2);
      wr(7'd19, mk(1'b1, 2'd2, 1'b1, 1'b1, 6'd0, 4'd2));
      wr(7'd17, 32'hD0);
      wr(7'h40, 32'b0110);
      rd(7'd11, d);  rd(7'd19, d2);
      chk(d[31] && d2[31], "R5 both busy same edge", {d[31], d2[31]}, 32'd3);
      repeat (3) @(negedge clk);
      rd(7'd10, d);  chk(d == 32'd2, "R7 paced hold", d, 32'd2);
      dreq[0] = 1'b1;
      @(negedge clk);
      rd(7'd10, d);  rd(7'd18, d2);
      chk(d == 32'd1 && d2 == 32'd2, "R11 lower index first", {d[15:0], d2[15:0]}, 32'h0001_0002);
      wait_idle(2);
      @(negedge clk);
      dreq[0] = 1'b0;
      ref_copy(8'h40, 8'hC0, 2, 2'd2, 1'b1, 1'b1);
      ref_copy(8'h60, 8'hD0, 2, 2'd2, 1'b1, 1'b1);
      chk_mem("R5 R7 paced data");
      wr(7'h43, 32'hF);

      // R7 out-of-range pacing select stalls
      wr(7'd8, 32'h40);
      wr(7'd10, 32'd1);
      wr(7'd11, mk(1'b1, 2'd2, 1'b1, 1'b1, 6'd20, 4'd1));
      wr(7'd12, 32'hC0);
      dreq = '1;
      repeat (5) @(negedge clk);
      rd(7'd10, d);  chk(d == 32'd1, "R7 invalid select stalls", d, 32'd1);
      dreq = '0;

      // R8 hand-off from channel 0 to channel 3
      wr(7'd24, 32'h70);
      wr(7'd26, 32'd2);
      wr(7'd27, mk(1'b1, 2'd2, 1'b1, 1'b1, 6'h3F, 4'd3));
      wr(7'd25, 32'hE0);
      wr(7'd0, 32'h00);
      wr(7'd2, 32'd1);
      wr(7'd3, mk(1'b1, 2'd2, 1'b1, 1'b1, 6'h3F, 4'd3));
      wr(7'd4, 32'hF0);
      @(negedge clk);
      rd(7'd27, d);  chk(!d[31], "R8 partner idle on finish edge", d, 32'd0);
      @(negedge clk);
      rd(7'd27, d);  chk(d[31], "R8 partner busy one cycle later", d, 32'h8000_0000);
      wait_idle(3);
      @(negedge clk);
      ref_copy(8'h00, 8'hF0, 1, 2'd2, 1'b1, 1'b1);
      ref_copy(8'h70, 8'hE0, 2, 2'd2, 1'b1, 1'b1);
      chk_mem("R8 chained data");
      rd(7'h43, d);  chk(d == 32'h9, "R8 status of pair", d, 32'h9);

      // R9 interrupt lines
      chk(!irq0 && !irq1, "R9 masked lines low", {30'd0, irq1, irq0}, 32'd0);
      wr(7'h42, 32'h8);
      chk(irq1 && !irq0, "R9 line1 enabled", {30'd0, irq1, irq0}, 32'd2);
      wr(7'h41, 32'h1);
      chk(irq0, "R9 line0 enabled", {31'd0, irq0}, 32'd1);
      wr(7'h43, 32'h8);
      chk(!irq1 && irq0, "R9 clear bit3", {30'd0, irq1, irq0}, 32'd1);
      wr(7'h43, 32'h1);
      chk(!irq0, "R9 clear bit0", {31'd0, irq0}, 32'd0);

      // R10 completion and clear on the same edge
      wr(7'd0, 32'h00);
      wr(7'd2, 32'd1);
      wr(7'd3, mk(1'b1, 2'd2, 1'b1, 1'b1, 6'h3F, 4'd0));
      wr(7'd4, 32'hF0);
      wr(7'h43, 32'h1);
      rd(7'h43, d);  chk(d[0], "R10 set wins over clear", d, 32'd1);
      chk(irq0, "R10 line0 follows status", {31'd0, irq0}, 32'd1);
      wr(7'h43, 32'h1);
      rd(7'h43, d);  chk(d == 32'd0, "R10 lone clear", d, 32'd0);
      ref_copy(8'h00, 8'hF0, 1, 2'd2, 1'b1, 1'b1);
      chk_mem("R10 data");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule